// File: doc/BRIEF.md
# DRAM Channel Steering and Address Normalization

This block takes a physical address that has already been routed to a node. It decides which of the node's two DRAM controller channels serves the address and rewrites the address into the form that channel's chip-select logic expects. The work runs in order. An optional region swap XORs a slice of the upper address with a programmed base. The block then decides whether the address falls in the high channel range and picks a channel through a fixed priority of modes, one of which hashes address bits. Next it subtracts the hoisting offset: the DRAM hole offset, the high-range base offset or the node's range base. Last, it squeezes out the address bits that node interleaving and channel interleaving consumed.

The channel and the normalized address come out of a single register stage behind a valid/ready handshake. Configuration fields are sampled in the cycle an address is accepted. Chip-select matching is left to the logic downstream.

Top module: `dcs_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An address is accepted when `in_valid` and `in_ready` are both 1, and the result appears with `out_valid` = 1 on the next clock. `in_ready` = 0 only while a result is held with `out_ready` = 0. A held result keeps `out_chan` and `out_addr` unchanged.
- R3: When `swap_en` = 1, address bits [47:34] are all zero and the 7-bit slice addr[33:27] either lies in `swap_base`..`swap_limit` or is below `swap_size`, that slice is XORed with `swap_base`. All later steps use the swapped address.
- R4: The high range is selected only when `hi_rng_en` = 1, `gang_en` = 0 and the address is at or above `sel_base` << 27.
- R5: When `gang_en` = 1, the channel is address bit 3, whatever the other modes are set to.
- R6: When R5 does not apply and the high range is selected, the channel is `hi_chan`.
- R7: When neither applies, `ilv_en` = 1 and `ilv_mode` = 0, the channel is address bit 6.
- R8: When `ilv_en` = 1 and `ilv_mode`[1] = 1, the channel is address bit 9 (if `ilv_mode`[0] = 1) or bit 6 (if it is 0), XORed with the odd parity of bits [20:16].
- R9: When `ilv_en` = 1 and `ilv_mode` = 1, the channel is address bit (12 + `node_ilog`).
- R10: When interleaving is off, `hi_rng_en` = 1 gives the inverse of `hi_chan`. With no mode active, the channel is 0.
- R11: The offset is `hole_off` << 23 when `hole_valid` = 1 and the address is at or above 4 GiB. In the high range this also needs `sel_base` << 27 to be below 4 GiB.
- R12: Otherwise the offset is `sel_off` << 26 in the high range and `node_base` outside it. The offset is subtracted from the address.
- R13: After the subtraction, the `node_ilog` bits just above bit 11 are removed. Higher bits shift down and bits [11:0] are kept.
- R14: With `ilv_en` = 1, the high range not selected and `gang_en` = 0, one more bit is removed: bit 6 when `ilv_mode`[0] = 0, bit 12 when `ilv_mode` = 1, and bit 9 when `ilv_mode` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address can be taken this cycle |
| in_addr | input | 48 | Physical address routed to this node |
| node_base | input | 48 | Node range base address |
| node_ilog | input | 2 | log2 of the node interleave count |
| gang_en | input | 1 | Both channels ganged |
| hi_rng_en | input | 1 | High channel range enable |
| hi_chan | input | 1 | Channel that owns the high range |
| ilv_en | input | 1 | Channel interleave enable |
| ilv_mode | input | 2 | Channel interleave address mode |
| sel_base | input | 21 | High range base, in units of 2^27 |
| sel_off | input | 22 | High range offset, in units of 2^26 |
| hole_valid | input | 1 | DRAM hole remap active |
| hole_off | input | 9 | Hole offset, in units of 2^23 |
| swap_en | input | 1 | Region swap enable |
| swap_base | input | 7 | Swap region base, in units of 2^27 |
| swap_limit | input | 7 | Swap region limit, in units of 2^27 |
| swap_size | input | 7 | Swap region size, in units of 2^27 |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream takes the result |
| out_chan | output | 1 | Selected channel |
| out_addr | output | 48 | Normalized channel address |

## Verification
The assertions check on every cycle the handshake rules: a held result stays stable, `in_ready` drops under backpressure, and every acceptance produces a result. They also check the channel-priority cases that need no arithmetic: ganged bit 3, the high-range channel, and channel 0 when no mode is active. The bench's scenarios are the only place where the region swap, the parity hash, the choice between hole and base offsets and the exact bit removal for each interleave mode can be seen. Each of these is compared against an address computed independently, including the ranges at and just below the high-range and 4 GiB boundaries.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int RGN_LSB    = 27;
  localparam int RGN_W      = 7;
  localparam int RGN_MSB    = RGN_LSB + RGN_W - 1;
  localparam int SEL_SHIFT  = 27;
  localparam int OFF_SHIFT  = 26;
  localparam int HOLE_SHIFT = 23;
  localparam int GIB4_BIT   = 32;
  localparam int PAGE_BITS  = 12;
  localparam int HASH_LO    = 16;
  localparam int HASH_HI    = 20;

  typedef enum logic [1:0] {
    MODE_BIT6   = 2'd0,
    MODE_PAGE   = 2'd1,
    MODE_HASH6  = 2'd2,
    MODE_HASH9  = 2'd3
  } ilv_mode_e;
endpackage

// File: rtl/dcs_steer.sv
module dcs_steer
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int ILOG_W = 2,
  parameter int SELB_W = ADDR_W - SEL_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ILOG_W-1:0] ilog_i,
  input  logic              gang_i,
  input  logic              hi_en_i,
  input  logic              hi_chan_i,
  input  logic              ilv_en_i,
  input  logic [1:0]        mode_i,
  input  logic [SELB_W-1:0] sel_base_i,
  input  logic              swap_en_i,
  input  logic [RGN_W-1:0]  swap_base_i,
  input  logic [RGN_W-1:0]  swap_limit_i,
  input  logic [RGN_W-1:0]  swap_size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hi_sel_o,
  output logic              chan_o
);
  logic [RGN_W-1:0]  rgn;
  logic              upper_clear;
  logic              do_swap;
  logic [ADDR_W-1:0] sel_base_full;
  logic              hash_par;
  logic              ilv_bit;

  assign rgn           = addr_i[RGN_MSB:RGN_LSB];
  assign upper_clear   = (addr_i[ADDR_W-1:RGN_MSB+1] == '0);
  assign do_swap       = swap_en_i && upper_clear &&
                         (((rgn >= swap_base_i) && (rgn <= swap_limit_i)) ||
                          (rgn < swap_size_i));
  assign sel_base_full = {sel_base_i, {SEL_SHIFT{1'b0}}};

  always_comb begin
    addr_o = addr_i;
    if (do_swap) addr_o[RGN_MSB:RGN_LSB] = rgn ^ swap_base_i;
  end

  assign hi_sel_o = hi_en_i && !gang_i && (addr_o >= sel_base_full);
  assign hash_par = ^addr_o[HASH_HI:HASH_LO];
  assign ilv_bit  = addr_o[PAGE_BITS + int'(ilog_i)];

  always_comb begin
    if (gang_i)                                  chan_o = addr_o[3];
    else if (hi_sel_o)                           chan_o = hi_chan_i;
    else if (ilv_en_i && mode_i == MODE_BIT6)    chan_o = addr_o[6];
    else if (ilv_en_i && mode_i[1])              chan_o = (mode_i[0] ? addr_o[9] : addr_o[6]) ^ hash_par;
    else if (ilv_en_i)                           chan_o = ilv_bit;
    else if (hi_en_i)                            chan_o = ~hi_chan_i;
    else                                         chan_o = 1'b0;
  end
endmodule

// File: rtl/dcs_norm.sv
module dcs_norm
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int ILOG_W = 2,
  parameter int SELB_W = ADDR_W - SEL_SHIFT,
  parameter int SELO_W = ADDR_W - OFF_SHIFT,
  parameter int HOLE_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hi_sel_i,
  input  logic [ADDR_W-1:0] node_base_i,
  input  logic [ILOG_W-1:0] ilog_i,
  input  logic              gang_i,
  input  logic              ilv_en_i,
  input  logic [1:0]        mode_i,
  input  logic [SELB_W-1:0] sel_base_i,
  input  logic [SELO_W-1:0] sel_off_i,
  input  logic              hole_valid_i,
  input  logic [HOLE_W-1:0] hole_off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NVAR = 1 << ILOG_W;

  function automatic logic [ADDR_W-1:0] drop_bit(input logic [ADDR_W-1:0] v, input int pos);
    logic [ADDR_W-1:0] lo_mask;
    lo_mask  = (ADDR_W'(1) << pos) - ADDR_W'(1);
    drop_bit = ((v >> (pos + 1)) << pos) | (v & lo_mask);
  endfunction

  logic              above_4g;
  logic              sel_low;
  logic              use_hole;
  logic [ADDR_W-1:0] hole_full;
  logic [ADDR_W-1:0] selo_full;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] rebased;
  logic [ADDR_W-1:0] node_var [NVAR];
  logic [ADDR_W-1:0] node_rm;

  assign above_4g  = (addr_i[ADDR_W-1:GIB4_BIT] != '0);
  assign sel_low   = (sel_base_i[SELB_W-1:GIB4_BIT-SEL_SHIFT] == '0);
  assign hole_full = ADDR_W'(hole_off_i) << HOLE_SHIFT;
  assign selo_full = ADDR_W'(sel_off_i) << OFF_SHIFT;
  assign use_hole  = hole_valid_i && above_4g && (!hi_sel_i || sel_low);

  always_comb begin
    if (use_hole)      offset = hole_full;
    else if (hi_sel_i) offset = selo_full;
    else               offset = node_base_i;
  end

  assign rebased = addr_i - offset;

  for (genvar k = 0; k < NVAR; k++) begin : g_node
    assign node_var[k] = ((rebased >> (PAGE_BITS + k)) << PAGE_BITS) |
                         {{(ADDR_W-PAGE_BITS){1'b0}}, rebased[PAGE_BITS-1:0]};
  end
  assign node_rm = node_var[ilog_i];

  always_comb begin
    addr_o = node_rm;
    if (ilv_en_i && !hi_sel_i && !gang_i) begin
      if (!mode_i[0])                addr_o = drop_bit(node_rm, 6);
      else if (mode_i == MODE_PAGE)  addr_o = drop_bit(node_rm, PAGE_BITS);
      else                           addr_o = drop_bit(node_rm, 9);
    end
  end
endmodule

// File: rtl/dcs_top.sv
module dcs_top
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int ILOG_W = 2,
  parameter int SELB_W = ADDR_W - SEL_SHIFT,
  parameter int SELO_W = ADDR_W - OFF_SHIFT,
  parameter int HOLE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] node_base,
  input  logic [ILOG_W-1:0] node_ilog,
  input  logic              gang_en,
  input  logic              hi_rng_en,
  input  logic              hi_chan,
  input  logic              ilv_en,
  input  logic [1:0]        ilv_mode,
  input  logic [SELB_W-1:0] sel_base,
  input  logic [SELO_W-1:0] sel_off,
  input  logic              hole_valid,
  input  logic [HOLE_W-1:0] hole_off,
  input  logic              swap_en,
  input  logic [RGN_W-1:0]  swap_base,
  input  logic [RGN_W-1:0]  swap_limit,
  input  logic [RGN_W-1:0]  swap_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_chan,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] swp_addr;
  logic              hi_sel;
  logic              chan_d;
  logic [ADDR_W-1:0] norm_d;
  logic              accept;
  logic              vld_q, vld_d;
  logic              chan_q;
  logic [ADDR_W-1:0] addr_q;

  dcs_steer #(.ADDR_W(ADDR_W), .ILOG_W(ILOG_W), .SELB_W(SELB_W)) u_steer (
    .addr_i(in_addr), .ilog_i(node_ilog), .gang_i(gang_en), .hi_en_i(hi_rng_en),
    .hi_chan_i(hi_chan), .ilv_en_i(ilv_en), .mode_i(ilv_mode), .sel_base_i(sel_base),
    .swap_en_i(swap_en), .swap_base_i(swap_base), .swap_limit_i(swap_limit),
    .swap_size_i(swap_size), .addr_o(swp_addr), .hi_sel_o(hi_sel), .chan_o(chan_d)
  );

  dcs_norm #(.ADDR_W(ADDR_W), .ILOG_W(ILOG_W), .SELB_W(SELB_W), .SELO_W(SELO_W),
             .HOLE_W(HOLE_W)) u_norm (
    .addr_i(swp_addr), .hi_sel_i(hi_sel), .node_base_i(node_base), .ilog_i(node_ilog),
    .gang_i(gang_en), .ilv_en_i(ilv_en), .mode_i(ilv_mode), .sel_base_i(sel_base),
    .sel_off_i(sel_off), .hole_valid_i(hole_valid), .hole_off_i(hole_off), .addr_o(norm_d)
  );

  always_comb begin
    in_ready = !vld_q || out_ready;
    accept   = in_valid && in_ready;
    if (accept)         vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      chan_q <= chan_d;
      addr_q <= norm_d;
    end
  end

  assign out_valid = vld_q;
  assign out_chan  = chan_q;
  assign out_addr  = addr_q;
endmodule

// File: rtl/dcs_top_chk.sv
module dcs_top_chk #(
  parameter int ADDR_W = 48,
  parameter int SELB_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              gang_en,
  input logic              hi_rng_en,
  input logic              hi_chan,
  input logic              ilv_en,
  input logic              swap_en,
  input logic [SELB_W-1:0] sel_base,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_chan,
  input logic [ADDR_W-1:0] out_addr
);
  localparam int SH = ADDR_W - SELB_W;

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_addr)); // R2

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2

  AST_ACCEPT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_GANG_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && gang_en |=> out_chan == $past(in_addr[3])); // R5

  AST_HIGH_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hi_rng_en && !gang_en && !swap_en &&
    (in_addr >= {sel_base, {SH{1'b0}}}) |=> out_chan == $past(hi_chan)); // R6

  AST_NO_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !gang_en && !hi_rng_en && !ilv_en |=> !out_chan); // R10
endmodule

bind dcs_top dcs_top_chk #(.ADDR_W(ADDR_W), .SELB_W(SELB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .gang_en(gang_en), .hi_rng_en(hi_rng_en), .hi_chan(hi_chan), .ilv_en(ilv_en),
  .swap_en(swap_en), .sel_base(sel_base), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_addr(out_addr)
);

// File: tb/dcs_top_bench.sv
module dcs_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_addr = '0;
  logic [47:0] node_base = '0;
  logic [1:0]  node_ilog = '0;
  logic        gang_en = 1'b0, hi_rng_en = 1'b0, hi_chan = 1'b0, ilv_en = 1'b0;
  logic [1:0]  ilv_mode = '0;
  logic [20:0] sel_base = '0;
  logic [21:0] sel_off = '0;
  logic        hole_valid = 1'b0;
  logic [8:0]  hole_off = '0;
  logic        swap_en = 1'b0;
  logic [6:0]  swap_base = '0, swap_limit = '0, swap_size = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_chan;
  logic [47:0] out_addr;

  int tests = 0;
  int fails = 0;
  int stall_pat = 0;
  logic [48:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  dcs_top u_dcs_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .node_base(node_base), .node_ilog(node_ilog), .gang_en(gang_en), .hi_rng_en(hi_rng_en),
    .hi_chan(hi_chan), .ilv_en(ilv_en), .ilv_mode(ilv_mode), .sel_base(sel_base),
    .sel_off(sel_off), .hole_valid(hole_valid), .hole_off(hole_off), .swap_en(swap_en),
    .swap_base(swap_base), .swap_limit(swap_limit), .swap_size(swap_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_addr(out_addr)
  );

  function automatic logic [47:0] rm_bit(input logic [47:0] v, input int p);
    return ((v >> (p + 1)) << p) | (v & ((48'd1 << p) - 48'd1));
  endfunction

  // Expected result from the requirements: {channel, address}
  function automatic logic [48:0] model(input logic [47:0] a0);
    logic [47:0] a, selb, off, ca;
    logic [6:0]  r;
    logic        hi, ch, big;
    a = a0;
    r = a[33:27];
    if (swap_en && a[47:34] == 0 && ((r >= swap_base && r <= swap_limit) || r < swap_size))
      a[33:27] = r ^ swap_base;                                   // R3
    selb = {sel_base, 27'd0};
    hi = hi_rng_en && !gang_en && a >= selb;                      // R4
    if (gang_en) ch = a[3];                                       // R5
    else if (hi) ch = hi_chan;                                    // R6
    else if (ilv_en && ilv_mode == 2'd0) ch = a[6];               // R7
    else if (ilv_en && ilv_mode[1])
      ch = (ilv_mode[0] ? a[9] : a[6]) ^ (a[16] ^ a[17] ^ a[18] ^ a[19] ^ a[20]); // R8
    else if (ilv_en) ch = a[12 + int'(node_ilog)];                // R9
    else if (hi_rng_en) ch = !hi_chan;                            // R10
    else ch = 1'b0;
    big = hole_valid && a >= 48'h1_0000_0000;
    if (hi) off = (big && selb < 48'h1_0000_0000) ? 48'(hole_off) << 23 : 48'(sel_off) << 26; // R11 R12
    else    off = big ? 48'(hole_off) << 23 : node_base;
    ca = a - off;
    ca = ((ca >> (12 + int'(node_ilog))) << 12) | (ca & 48'hFFF); // R13
    if (ilv_en && !hi && !gang_en) begin                          // R14
      if (!ilv_mode[0]) ca = rm_bit(ca, 6);
      else if (ilv_mode == 2'd1) ca = rm_bit(ca, 12);
      else ca = rm_bit(ca, 9);
    end
    return {ch, ca};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [47:0] a);
    @(negedge clk);
    in_addr  = a;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(a));
    tag_q.push_back(req);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Monitor: pattern-driven backpressure, compare on each transfer
  initial begin
    forever begin
      @(negedge clk);
      stall_pat++;
      out_ready = (stall_pat % 5) != 3;
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected output", 64'(out_valid), 64'd0);
        end else begin
          logic [48:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " channel"}, 64'(out_chan), 64'(e[48]));
          check({t, " address"}, 64'(out_addr), 64'(e[47:0]));
        end
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    check("R1 in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: ganged overrides high range
    gang_en = 1; hi_rng_en = 1; hi_chan = 0; sel_base = 21'd2;
    send("R5", 48'h0000_1234_5608);
    send("R5", 48'h0000_1234_5600);
    gang_en = 0;

    // R4 R6 R12: high range, base offset
    hi_chan = 1; sel_off = 22'd1;
    send("R6", 48'h0000_1000_0040);
    send("R4", 48'h0000_1000_0000);
    // R4 R10: just below the high range, inverse channel
    send("R10", 48'h0000_0FFF_FFC0);
    hi_rng_en = 0; hi_chan = 0;

    // R7 R14: mode 0
    ilv_en = 1; ilv_mode = 2'd0;
    send("R7", 48'h0000_0000_1040);
    send("R14", 48'h0000_0000_10BF);
    // R8: hash modes
    ilv_mode = 2'd2;
    send("R8", 48'h0000_0001_0000);
    send("R8", 48'h0000_0003_0040);
    ilv_mode = 2'd3;
    send("R8", 48'h0000_0003_0200);
    send("R8", 48'h0000_0011_0000);
    // R9 R13: page mode with node interleave
    ilv_mode = 2'd1; node_ilog = 2'd1; node_base = 48'h1_0000_0000;
    send("R9", 48'h0001_0000_3ABC);
    send("R13", 48'h0001_0000_5ABC);
    node_ilog = 2'd3; ilv_en = 0;
    send("R13", 48'h0001_0012_3456);
    node_ilog = 2'd0; node_base = '0;

    // R11: hole offset outside the high range
    hole_valid = 1; hole_off = 9'h1E0;
    send("R11", 48'h0001_2000_0000);
    send("R12", 48'h0000_FFFF_F000);
    // R11: high range with base above 4 GiB keeps base offset
    hi_rng_en = 1; hi_chan = 1; sel_base = 21'h40; sel_off = 22'h10;
    send("R11", 48'h0002_4000_0000);
    // R11: high range with base below 4 GiB takes hole offset
    sel_base = 21'd2;
    send("R11", 48'h0001_0000_1000);
    hi_rng_en = 0; hi_chan = 0; hole_valid = 0; sel_base = '0; sel_off = '0;

    // R3: region swap
    swap_en = 1; swap_base = 7'd1; swap_limit = 7'd1; swap_size = 7'd1;
    send("R3", 48'h0000_0000_0100);
    send("R3", 48'h0000_0800_0200);
    send("R3", 48'h0000_1000_0300);
    send("R3", 48'h0004_0000_0000);
    swap_en = 0;

    // R10: no mode at all
    send("R10", 48'h0000_DEAD_BEE8);

    // R2: burst with no idle cycles under backpressure
    ilv_en = 1; ilv_mode = 2'd2;
    for (int i = 0; i < 12; i++) send("R2", 48'(64'h1_0000 * i + 64'h40 * i));

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule